// File: doc/BRIEF.md
# Converter Sample Formatter with Block FIFO

This block sits between a bank of simultaneously sampled converters and a processor that empties captured data in blocks. Each input beat carries one raw word per converter channel. The block throws away the beats that a pipelined converter produces before its output becomes valid, then formats every remaining channel word. A word is either kept as straight binary or turned into a sign-extended two's complement value. A pair of channels can instead be subtracted to form one differential value. The results go into a FIFO in ascending channel order, one beat after another.

The FIFO is read through a valid/ready stream. It can deliver one sample per word, or pack two samples of the same beat into one 32-bit word. Empty, half-full and full flags, a sticky overflow bit and a maskable interrupt request let the processor start a block transfer at the right time. Input back-pressure exists only while a beat is being unpacked channel by channel. A full FIFO never stalls the converters: the samples that do not fit are lost, and the loss is recorded. Configuration inputs are expected to change only together with a `clr` pulse.

Top module: `sample_fmt_fifo`

## Requirements
- R1: After reset, and after each `clr` pulse, the first DISCARD accepted beats are dropped, so that DISCARD samples of every channel are lost. These beats are still accepted (`in_ready` high) but write nothing.
- R2: In unipolar mode (`cfg_bipolar`=0), each sample is stored right-justified and zero-extended to 16 bits. Raw bits above the resolution are ignored. `cfg_res` selects the resolution: 0 gives 12 bits, 1 gives 14 bits, 2 or 3 give 16 bits.
- R3: In bipolar mode, the offset-binary raw code is stored as two's complement (code minus half scale) and sign-extended through bit 15.
- R4: The samples of one beat enter the FIFO in ascending channel order for channels 0 to `cfg_nch`-1, and beats keep their arrival order. Channels at or above `cfg_nch` are not stored.
- R5: When bit p of `cfg_diff` is set and channel 2p+1 is below `cfg_nch`, channels 2p and 2p+1 produce a single sample in the slot of channel 2p. That sample is the masked code of 2p minus the masked code of 2p+1, saturated to the range 0x8000..0x7FFF. Single-ended channels and differential pairs may be mixed.
- R6: In narrow mode (`cfg_wide`=0), each FIFO word holds one sample in bits 15:0 with bits 31:16 zero.
- R7: In wide mode, consecutive samples of one beat are packed in pairs, the earlier sample in bits 15:0. When a beat has an odd sample count, its last sample goes out alone with bits 31:16 zero.
- R8: `fifo_empty` is high when no word is stored, `fifo_half` when at least DEPTH/2 words are stored, and `fifo_full` when DEPTH words are stored.
- R9: A word produced while the FIFO is full is dropped, the words already stored are unchanged, and `overflow` is set. `overflow` stays set until `clr`.
- R10: `clr` empties the FIFO, clears `overflow` and the partial pack state, and restarts the discard of R1.
- R11: `irq` is the OR of the flags selected by `irq_mask`: bit 0 selects FIFO not empty, bit 1 selects half-full and bit 2 selects full.
- R12: A beat held on the input is taken only when `in_ready` is high. `in_ready` is low while a kept beat is being unpacked, except in its final slot. `out_data` stays stable while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart: flush, clear overflow, restart discard |
| cfg_nch | input | $clog2(NCH+1) | Number of active converter channels (1..NCH) |
| cfg_res | input | 2 | Resolution select: 0 = 12, 1 = 14, else 16 bits |
| cfg_bipolar | input | 1 | 1 = two's complement output, 0 = straight binary |
| cfg_diff | input | NCH/2 | One bit per channel pair; set = differential pair |
| cfg_wide | input | 1 | 1 = two samples per 32-bit output word |
| irq_mask | input | 3 | Interrupt sources: {full, half, not empty} |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when high with in_valid |
| in_data | input | NCH*16 | Raw words, channel c in bits 16c+15:16c |
| out_valid | output | 1 | FIFO word available |
| out_ready | input | 1 | Reader takes the word |
| out_data | output | 32 | FIFO head word |
| fifo_empty | output | 1 | No words stored |
| fifo_half | output | 1 | At least DEPTH/2 words stored |
| fifo_full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check cycle-local rules on every clock edge. The overflow bit never falls without `clr`, and a write into a full FIFO leaves it full with overflow set. The empty and full flags never coexist, a stalled output word holds still, a discarded beat starts no unpacking, and the pack register is empty after each beat. The value-level behaviour can be shown only by the bench's scenarios, with expected words computed independently: the discard count, the unipolar, bipolar and differential formats with saturation, the channel order, the odd-sample padding, the flag thresholds and the interrupt masking.

// File: rtl/sfmt_pkg.sv
`timescale 1ns/1ps
package sfmt_pkg;

  typedef struct packed {
    logic full;
    logic half;
    logic nonempty;
  } fifo_flags_t;

  // keep only the bits of the selected resolution, right-justified
  function automatic logic [15:0] res_mask(input logic [15:0] raw, input logic [1:0] res);
    case (res)
      2'd0:    return {4'h0, raw[11:0]};
      2'd1:    return {2'b00, raw[13:0]};
      default: return raw;
    endcase
  endfunction

  // straight binary or offset-binary to two's complement with sign extension
  function automatic logic [15:0] fmt_sample(input logic [15:0] raw, input logic [1:0] res,
                                             input logic bip);
    logic [15:0] v;
    v = res_mask(raw, res);
    if (!bip) return v;
    case (res)
      2'd0:    return {{5{~v[11]}}, v[10:0]};
      2'd1:    return {{3{~v[13]}}, v[12:0]};
      default: return {~v[15], v[14:0]};
    endcase
  endfunction

  // positive leg minus negative leg, saturated to 16-bit signed
  function automatic logic [15:0] diff_sample(input logic [15:0] pos, input logic [15:0] neg,
                                              input logic [1:0] res);
    logic signed [16:0] d;
    d = $signed({1'b0, res_mask(pos, res)}) - $signed({1'b0, res_mask(neg, res)});
    if (d > 17'sd32767) return 16'h7FFF;
    if (d < -17'sd32768) return 16'h8000;
    return d[15:0];
  endfunction

endpackage

// File: rtl/sfmt_format.sv
`timescale 1ns/1ps
module sfmt_format
  import sfmt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*16-1:0]     raw,
  input  logic [1:0]            res,
  input  logic                  bipolar,
  output logic [NCH*16-1:0]     se_words,
  output logic [(NCH/2)*16-1:0] df_words
);
  localparam int PAIRS = NCH / 2;

  for (genvar c = 0; c < NCH; c++) begin : g_se
    assign se_words[c*16 +: 16] = fmt_sample(raw[c*16 +: 16], res, bipolar);
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_df
    assign df_words[p*16 +: 16] = diff_sample(raw[(2*p)*16 +: 16], raw[(2*p+1)*16 +: 16], res);
  end

endmodule

// File: rtl/sfmt_sequencer.sv
`timescale 1ns/1ps
module sfmt_sequencer #(
  parameter int NCH     = 4,
  parameter int DISCARD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [$clog2(NCH+1)-1:0]  cfg_nch,
  input  logic [NCH/2-1:0]          cfg_diff,
  input  logic                      cfg_wide,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NCH*16-1:0]         in_data,
  output logic [NCH*16-1:0]         raw_q,
  input  logic [NCH*16-1:0]         se_words,
  input  logic [(NCH/2)*16-1:0]     df_words,
  output logic                      wr_en,
  output logic [31:0]               wr_data
);
  localparam int CNT_W = $clog2(NCH + 1);
  localparam int IDX_W = $clog2(NCH);
  localparam int DW    = $clog2(DISCARD + 1);

  logic             busy;
  logic [CNT_W-1:0] ch;
  logic [DW-1:0]    disc_cnt;
  logic             have_lo;
  logic [15:0]      lo_q;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-2:0] pidx;
  logic             pair_here;
  logic [CNT_W:0]   nxt;
  logic             last;
  logic             keep;
  logic             in_fire;
  logic [15:0]      sample;

  assign idx       = ch[IDX_W-1:0];
  assign pidx      = ch[IDX_W-1:1];
  assign pair_here = cfg_diff[pidx] && !ch[0] && (({1'b0, ch} + 1'b1) < {1'b0, cfg_nch});
  assign nxt       = {1'b0, ch} + (pair_here ? 2 : 1);
  assign last      = busy && (nxt >= {1'b0, cfg_nch});
  assign keep      = (disc_cnt == DW'(DISCARD));
  assign in_ready  = !busy || last;
  assign in_fire   = in_valid && in_ready;
  assign sample    = pair_here ? df_words[pidx*16 +: 16] : se_words[idx*16 +: 16];

  always_comb begin
    wr_en   = 1'b0;
    wr_data = 32'h0;
    if (busy) begin
      if (!cfg_wide) begin
        wr_en   = 1'b1;
        wr_data = {16'h0, sample};
      end else if (have_lo) begin
        wr_en   = 1'b1;
        wr_data = {sample, lo_q};
      end else if (last) begin
        wr_en   = 1'b1;
        wr_data = {16'h0, sample};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ch       <= '0;
      disc_cnt <= '0;
      have_lo  <= 1'b0;
      lo_q     <= '0;
      raw_q    <= '0;
    end else if (clr) begin
      busy     <= 1'b0;
      ch       <= '0;
      disc_cnt <= '0;
      have_lo  <= 1'b0;
    end else begin
      if (busy) begin
        ch <= nxt[CNT_W-1:0];
        if (last) busy <= 1'b0;
        if (cfg_wide) begin
          have_lo <= !have_lo && !last;
          lo_q    <= sample;
        end
      end
      if (in_fire) begin
        if (keep) begin
          raw_q <= in_data;
          busy  <= 1'b1;
          ch    <= '0;
        end else begin
          disc_cnt <= disc_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  discard_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !keep && !clr) |=> !busy)
    else $error("discarded beat started unpacking");

  // R7
  pack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr) |=> !have_lo)
    else $error("pack register not empty after a beat");

endmodule

// File: rtl/sfmt_fifo.sv
`timescale 1ns/1ps
module sfmt_fifo #(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        empty,
  output logic        half,
  output logic        full,
  output logic        overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          wr_ok, rd_ok;

  assign empty    = (count == '0);
  assign full     = (count == (AW+1)'(DEPTH));
  assign half     = (count >= (AW+1)'(DEPTH/2));
  assign rd_valid = !empty;
  assign rd_data  = mem[rptr];
  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow)
    else $error("overflow fell without clr");

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !clr) |=> (full && overflow))
    else $error("write into full FIFO not handled");

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full))
    else $error("empty and full together");

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en && !clr) |=> (rd_valid && $stable(rd_data)))
    else $error("stalled output word changed");

endmodule

// File: rtl/sample_fmt_fifo.sv
`timescale 1ns/1ps
module sample_fmt_fifo
  import sfmt_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DEPTH   = 256,
  parameter int DISCARD = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [$clog2(NCH+1)-1:0] cfg_nch,
  input  logic [1:0]               cfg_res,
  input  logic                     cfg_bipolar,
  input  logic [NCH/2-1:0]         cfg_diff,
  input  logic                     cfg_wide,
  input  logic [2:0]               irq_mask,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NCH*16-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [31:0]              out_data,
  output logic                     fifo_empty,
  output logic                     fifo_half,
  output logic                     fifo_full,
  output logic                     overflow,
  output logic                     irq
);
  localparam int PAIRS = NCH / 2;

  logic [NCH*16-1:0]   raw_q;
  logic [NCH*16-1:0]   se_words;
  logic [PAIRS*16-1:0] df_words;
  logic                wr_en;
  logic [31:0]         wr_data;
  fifo_flags_t         flags;

  sfmt_sequencer #(.NCH(NCH), .DISCARD(DISCARD)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cfg_nch(cfg_nch), .cfg_diff(cfg_diff), .cfg_wide(cfg_wide),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .raw_q(raw_q), .se_words(se_words), .df_words(df_words),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  sfmt_format #(.NCH(NCH)) u_fmt (
    .raw(raw_q), .res(cfg_res), .bipolar(cfg_bipolar),
    .se_words(se_words), .df_words(df_words)
  );

  sfmt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(out_ready), .rd_valid(out_valid), .rd_data(out_data),
    .empty(fifo_empty), .half(fifo_half), .full(fifo_full), .overflow(overflow)
  );

  assign flags.full     = fifo_full;
  assign flags.half     = fifo_half;
  assign flags.nonempty = !fifo_empty;
  assign irq            = |(irq_mask & flags);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !fifo_empty)
    else $error("irq with empty FIFO");

  // R8
  full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> fifo_half)
    else $error("full without half");

endmodule

// File: tb/sample_fmt_fifo_bench.sv
`timescale 1ns/1ps
module sample_fmt_fifo_bench;
  localparam int NCH   = 4;
  localparam int DEPTH = 16;
  localparam int DISC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  cfg_nch = 3'd4;
  logic [1:0]  cfg_res = 2'd0;
  logic        cfg_bipolar = 1'b0;
  logic [1:0]  cfg_diff = 2'b00;
  logic        cfg_wide = 1'b0;
  logic [2:0]  irq_mask = 3'b000;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        fifo_empty, fifo_half, fifo_full, overflow, irq;

  int checks = 0;
  int failures = 0;
  int disc = 0;
  bit exp_ovf = 0;
  logic [31:0] q[$];

  always #2.5 clk = ~clk;

  sample_fmt_fifo #(.NCH(NCH), .DEPTH(DEPTH), .DISCARD(DISC)) u_sample_fmt_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cfg_nch(cfg_nch), .cfg_res(cfg_res), .cfg_bipolar(cfg_bipolar),
    .cfg_diff(cfg_diff), .cfg_wide(cfg_wide), .irq_mask(irq_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full),
    .overflow(overflow), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int bits_of(input logic [1:0] r);
    return (r == 2'd0) ? 12 : (r == 2'd1) ? 14 : 16;
  endfunction

  function automatic logic [15:0] ref_fmt(input logic [15:0] raw);
    int n, v;
    n = bits_of(cfg_res);
    v = int'(raw) % (1 << n);
    if (cfg_bipolar) v = v - (1 << (n - 1));
    return 16'(v);
  endfunction

  function automatic logic [15:0] ref_diff(input logic [15:0] a, input logic [15:0] b);
    int n, d;
    n = bits_of(cfg_res);
    d = (int'(a) % (1 << n)) - (int'(b) % (1 << n));
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return 16'(d);
  endfunction

  function automatic void push_word(input logic [31:0] w);
    if (q.size() == DEPTH) exp_ovf = 1;
    else q.push_back(w);
  endfunction

  function automatic void model_beat(input logic [63:0] d);
    logic [15:0] s[$];
    int c;
    if (disc < DISC) begin
      disc++;
      return;
    end
    c = 0;
    while (c < int'(cfg_nch)) begin
      if (cfg_diff[c/2] && (c % 2 == 0) && (c + 1 < int'(cfg_nch))) begin
        s.push_back(ref_diff(d[c*16 +: 16], d[(c+1)*16 +: 16]));
        c += 2;
      end else begin
        s.push_back(ref_fmt(d[c*16 +: 16]));
        c += 1;
      end
    end
    if (!cfg_wide) begin
      foreach (s[i]) push_word({16'h0, s[i]});
    end else begin
      for (int i = 0; i < s.size(); i += 2) begin
        if (i + 1 < s.size()) push_word({s[i+1], s[i]});
        else push_word({16'h0, s[i]});
      end
    end
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [63:0] d);
    bit ok;
    model_beat(d);
    in_valid = 1'b1;
    in_data  = d;
    do begin
      ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic restart(input logic [2:0] n, input logic [1:0] r, input logic b,
                         input logic [1:0] df, input logic w, input logic [2:0] m);
    @(negedge clk);
    cfg_nch = n; cfg_res = r; cfg_bipolar = b; cfg_diff = df; cfg_wide = w; irq_mask = m;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    disc = 0;
    exp_ovf = 0;
    q.delete();
  endtask

  task automatic drain(input string tag);
    int sz;
    logic [31:0] held;
    repeat (8) @(negedge clk);
    sz = q.size();
    chk(fifo_empty == (sz == 0), "R8", {tag, " empty"}, 32'(fifo_empty), 32'(sz == 0));
    chk(fifo_half == (sz >= DEPTH/2), "R8", {tag, " half"}, 32'(fifo_half), 32'(sz >= DEPTH/2));
    chk(fifo_full == (sz == DEPTH), "R8", {tag, " full"}, 32'(fifo_full), 32'(sz == DEPTH));
    chk(overflow == exp_ovf, "R9", {tag, " overflow"}, 32'(overflow), 32'(exp_ovf));
    chk(irq == |(irq_mask & {sz == DEPTH, sz >= DEPTH/2, sz != 0}), "R11", {tag, " irq"},
        32'(irq), 32'(|(irq_mask & {sz == DEPTH, sz >= DEPTH/2, sz != 0})));
    if (sz > 0) begin
      held = out_data;
      repeat (2) @(negedge clk);
      chk(out_valid && out_data == held, "R12", {tag, " stalled output"}, out_data, held);
    end
    out_ready = 1'b1;
    while (q.size() > 0) begin
      logic [31:0] e;
      e = q.pop_front();
      chk(out_valid && out_data == e, tag, "data word", out_data, e);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(fifo_empty && !out_valid, "R8", {tag, " empty after drain"}, 32'(fifo_empty), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    chk(in_ready == 1'b1, "R12", "reset in_ready", 32'(in_ready), 32'h1);
    chk(fifo_empty && !fifo_half && !fifo_full, "R8", "reset flags",
        {29'h0, fifo_empty, fifo_half, fifo_full}, 32'h4);
    chk(!overflow && !irq && !out_valid, "R9", "reset overflow/irq",
        {30'h0, overflow, irq}, 32'h0);
    rst_n = 1'b1;

    // R1 R2 R4 R6 R12: unipolar 12-bit, narrow, back-pressure during unpacking
    restart(3'd4, 2'd0, 1'b0, 2'b00, 1'b0, 3'b001);
    for (int i = 0; i < DISC; i++) send({16'hF000 + 16'(i), 16'hE111, 16'hD222, 16'hC333});
    repeat (6) @(negedge clk);
    chk(fifo_empty, "R1", "discarded beats store nothing", 32'(fifo_empty), 32'h1);
    model_beat(64'hF123_8FFF_0001_AABC);
    in_valid = 1'b1;
    in_data  = 64'hF123_8FFF_0001_AABC;
    @(negedge clk);
    chk(in_ready == 1'b0, "R12", "in_ready low mid-beat", 32'(in_ready), 32'h0);
    send(64'h0FFF_1000_2000_3000);
    drain("R2 R4 R6");

    // R3: bipolar 14-bit
    restart(3'd4, 2'd1, 1'b1, 2'b00, 1'b0, 3'b000);
    for (int i = 0; i < DISC; i++) send('0);
    send(64'hFFFF_3FFF_2000_C000);
    send(64'h0001_1FFF_DFFF_0000);
    drain("R3");

    // R5: differential pairs with saturation, 16-bit
    restart(3'd4, 2'd2, 1'b0, 2'b11, 1'b0, 3'b000);
    for (int i = 0; i < DISC; i++) send('0);
    send(64'hFFFF_0000_0000_FFFF);
    send(64'h1234_1000_0005_0003);
    drain("R5");

    // R5: mixed pair and single channels, odd channel count
    restart(3'd3, 2'd0, 1'b1, 2'b11, 1'b0, 3'b000);
    for (int i = 0; i < DISC; i++) send('0);
    send(64'h0000_0ABC_0100_0F00);
    drain("R5 mixed");

    // R7: wide packing, odd count padded
    restart(3'd3, 2'd2, 1'b0, 2'b00, 1'b1, 3'b000);
    for (int i = 0; i < DISC; i++) send('0);
    send(64'h0000_3333_2222_1111);
    send(64'h0000_6666_5555_4444);
    drain("R7");

    // R8 R9 R11: overflow with full interrupt
    restart(3'd4, 2'd2, 1'b0, 2'b00, 1'b0, 3'b100);
    for (int i = 0; i < DISC; i++) send('0);
    for (int i = 0; i < 5; i++) send({16'(i*4+3), 16'(i*4+2), 16'(i*4+1), 16'(i*4)});
    repeat (8) @(negedge clk);
    chk(fifo_full && overflow && irq, "R9", "overflow after excess beats",
        {29'h0, fifo_full, overflow, irq}, 32'h7);
    // R10: clr flushes and restarts discard
    restart(3'd4, 2'd2, 1'b0, 2'b00, 1'b0, 3'b001);
    chk(fifo_empty && !overflow, "R10", "clr flushes", {30'h0, fifo_empty, overflow}, 32'h2);
    for (int i = 0; i < DISC - 1; i++) send(64'h1111_2222_3333_4444);
    repeat (6) @(negedge clk);
    chk(fifo_empty && !irq, "R10", "discard restarted", {30'h0, fifo_empty, irq}, 32'h2);
    send(64'h1111_2222_3333_4444);
    send(64'h5555_6666_7777_8888);
    drain("R10 R1");

    // random configurations
    for (int it = 0; it < 30; it++) begin
      int nb;
      restart(3'(1 + $urandom % 4), 2'($urandom % 4), 1'($urandom % 2),
              2'($urandom % 4), 1'($urandom % 2), 3'($urandom % 8));
      nb = 2 + $urandom % 8;
      for (int b = 0; b < nb; b++) send({$urandom, $urandom});
      drain("R4 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule